// File: doc/BRIEF.md
# Selectable-Width Receive Packing Queue

This block takes the character stream produced by a serial receiver and turns it into writes toward a receive buffer. Each incoming character comes with a valid strobe and an optional end-of-frame mark. Writes leave the block on a ready/valid port that carries a 32-bit data word and a 4-bit byte-enable mask.

A single mode input selects how the characters are queued. In wide mode, characters are gathered into 32-bit words and the queue holds 32 bytes as eight words. A word is written out only when all four lanes are filled or when a character marked as end of frame arrives. Wide mode suits frame-oriented protocols that need full throughput. In narrow mode, every character becomes its own write at once. The queue then holds only a quarter as much, eight characters. Narrow mode suits character-oriented links where latency matters more than bus efficiency.

If a character arrives while the queue is full, it is discarded and a one-cycle overflow pulse is raised. A request to change mode is held back until the queue and the partial word are both empty.

Top module: `rx_pack_fifo`

## Requirements
- R1: After reset, `wr_vld_o` and `ovf_o` are low, `wr_data_o` and `wr_be_o` are zero, and the active mode is wide.
- R2: In wide mode, four accepted characters form one word, with the first character in bits 7:0 and the fourth in bits 31:24. `wr_be_o` is 4'b1111. The word is presented on the clock edge that accepts the fourth character, so `wr_vld_o` is high in the following cycle.
- R3: In wide mode, no write is presented while fewer than four characters of a word have been accepted and none of them carried the end-of-frame mark.
- R4: In wide mode, a character with `rx_eof_i` high flushes the partial word. Its byte enables are set for lanes 0 to n-1, where n is the number of characters held, and the data bits of unused lanes are zero.
- R5: In narrow mode, every accepted character is presented alone in the cycle after it is accepted. `wr_data_o[7:0]` holds the character, the upper bits are zero, and `wr_be_o` is 4'b0001.
- R6: The queue holds 8 words in wide mode (32 bytes) and 8 characters in narrow mode. A character that arrives while the queue is full is dropped, and `ovf_o` is high for exactly the one following cycle.
- R7: A character that arrives while the queue is full is dropped even if the head is popped in that same cycle.
- R8: A change on `narrow_i` takes effect only in a cycle where the queue is empty, no partial word is held and `rx_vld_i` is low. Characters accepted before that cycle keep the old mode.
- R9: While `wr_vld_o` is high and `wr_rdy_i` is low, the presented data and enables hold steady. Writes leave in the order they were formed.
- R10: A push and a pop in the same cycle both take effect. The head is replaced by the next entry and no entry is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| narrow_i | input | 1 | Mode request: 1 narrow (per character), 0 wide (32-bit packing) |
| rx_vld_i | input | 1 | A received character is present this cycle |
| rx_byte_i | input | 8 | Received character |
| rx_eof_i | input | 1 | The present character ends a frame (qualified by rx_vld_i) |
| wr_vld_o | output | 1 | A buffer write is available |
| wr_rdy_i | input | 1 | The buffer takes the write this cycle |
| wr_data_o | output | 32 | Write data, lane 0 in bits 7:0 |
| wr_be_o | output | 4 | Byte enables, one per lane |
| ovf_o | output | 1 | One-cycle pulse after a character was dropped |

## Verification
Two functions can fall in the same clock cycle: accepting a character (push) and handing the head to the buffer (pop). The bench provokes this in two ways.

In the first, a character is sent in the same cycle that `wr_rdy_i` pops a non-full queue. It is judged by the new character appearing at the head with nothing else left.

In the second, a character is sent against a full queue while the head is popped. The dropped character must never appear when the queue is drained, and the overflow pulse must follow.

// File: rtl/rxpk_pkg.sv
package rxpk_pkg;

  localparam int unsigned LANES      = 4;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned WORD_W     = LANES * BYTE_W;
  localparam int unsigned LANE_IDX_W = $clog2(LANES);

  typedef enum logic {
    MODE_WIDE   = 1'b0,
    MODE_NARROW = 1'b1
  } rx_mode_e;

  typedef struct packed {
    logic [WORD_W-1:0] data;
    logic [LANES-1:0]  be;
  } wr_entry_t;

  // one-hot enable for a single lane
  function automatic logic [LANES-1:0] lane_bit(input logic [LANE_IDX_W-1:0] lane);
    logic [LANES-1:0] r;
    r       = '0;
    r[lane] = 1'b1;
    return r;
  endfunction

  // a lone character placed in lane 0, the rest zero
  function automatic logic [WORD_W-1:0] lone_char(input logic [BYTE_W-1:0] b);
    return {{(WORD_W-BYTE_W){1'b0}}, b};
  endfunction

endpackage

// File: rtl/rxpk_mode_ctl.sv
module rxpk_mode_ctl
  import rxpk_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     narrow_req_i,
  input  logic     idle_i,
  output rx_mode_e mode_o
);

  rx_mode_e req_mode;
  assign req_mode = narrow_req_i ? MODE_NARROW : MODE_WIDE;

  // the active mode only follows the request while nothing is in flight
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      mode_o <= MODE_WIDE;
    end else if (idle_i) begin
      mode_o <= req_mode;
    end
  end

endmodule

// File: rtl/rxpk_packer.sv
module rxpk_packer
  import rxpk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              eof_i,
  input  rx_mode_e          mode_i,
  output logic              push_o,
  output wr_entry_t         entry_o,
  output logic              busy_o
);

  logic [WORD_W-1:0]     acc_data_q;
  logic [LANES-1:0]      acc_be_q;
  logic [LANE_IDX_W-1:0] fill_q;
  logic [WORD_W-1:0]     merged;
  logic [LANES-1:0]      merged_be;
  logic                  last_lane;
  logic                  wide_close;

  // steer the incoming character into the lane given by the fill count
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic hit;
    assign hit = (fill_q == LANE_IDX_W'(g));
    assign merged[g*BYTE_W +: BYTE_W] = hit ? byte_i : acc_data_q[g*BYTE_W +: BYTE_W];
  end

  assign merged_be  = acc_be_q | lane_bit(fill_q);
  assign last_lane  = (fill_q == LANE_IDX_W'(LANES-1));
  assign wide_close = take_i && (mode_i == MODE_WIDE) && (last_lane || eof_i);
  assign busy_o     = (fill_q != '0);

  always_comb begin
    push_o  = 1'b0;
    entry_o = '0;
    if (take_i && (mode_i == MODE_NARROW)) begin
      push_o       = 1'b1;
      entry_o.data = lone_char(byte_i);
      entry_o.be   = lane_bit('0);
    end else if (wide_close) begin
      push_o       = 1'b1;
      entry_o.data = merged;
      entry_o.be   = merged_be;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      acc_data_q <= '0;
      acc_be_q   <= '0;
      fill_q     <= '0;
    end else if (wide_close) begin
      acc_data_q <= '0;
      acc_be_q   <= '0;
      fill_q     <= '0;
    end else if (take_i && (mode_i == MODE_WIDE)) begin
      acc_data_q <= merged;
      acc_be_q   <= merged_be;
      fill_q     <= fill_q + 1'b1;
    end
  end

endmodule

// File: rtl/rxpk_store.sv
module rxpk_store
  import rxpk_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  wr_entry_t        push_entry_i,
  input  logic             pop_i,
  input  logic [CNT_W-1:0] cap_i,
  output wr_entry_t        head_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  wr_entry_t        mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q;
  logic [PTR_W-1:0] rd_ptr_q;

  assign head_o  = mem[rd_ptr_q];
  assign full_o  = (count_o >= cap_i);
  assign empty_o = (count_o == '0);

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      mem[wr_ptr_q] <= push_entry_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_o  <= '0;
    end else begin
      if (push_i) wr_ptr_q <= step(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= step(rd_ptr_q);
      case ({push_i, pop_i})
        2'b10:   count_o <= count_o + 1'b1;
        2'b01:   count_o <= count_o - 1'b1;
        default: count_o <= count_o;
      endcase
    end
  end

endmodule

// File: rtl/rx_pack_fifo.sv
module rx_pack_fifo
  import rxpk_pkg::*;
#(
  parameter int unsigned WIDE_BYTES = 32,
  parameter int unsigned NARROW_DIV = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              narrow_i,
  input  logic              rx_vld_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic              rx_eof_i,
  output logic              wr_vld_o,
  input  logic              wr_rdy_i,
  output logic [WORD_W-1:0] wr_data_o,
  output logic [LANES-1:0]  wr_be_o,
  output logic              ovf_o
);

  localparam int unsigned WIDE_ENTRIES   = WIDE_BYTES / LANES;
  localparam int unsigned NARROW_ENTRIES = WIDE_BYTES / NARROW_DIV;
  localparam int unsigned DEPTH          = (WIDE_ENTRIES > NARROW_ENTRIES) ? WIDE_ENTRIES : NARROW_ENTRIES;
  localparam int unsigned CNT_W          = $clog2(DEPTH + 1);

  // named internal events, observed by the bound checker
  rx_mode_e         mode_q;
  logic             take_evt;
  logic             drop_evt;
  logic             push_evt;
  logic             pop_evt;
  logic             pack_busy;
  logic             fifo_full;
  logic             fifo_empty;
  logic [CNT_W-1:0] fifo_count;
  logic [CNT_W-1:0] fifo_cap;
  logic             mode_idle;
  wr_entry_t        push_entry;
  wr_entry_t        head;
  logic             ovf_q;

  assign fifo_cap  = (mode_q == MODE_NARROW) ? CNT_W'(NARROW_ENTRIES) : CNT_W'(WIDE_ENTRIES);
  assign take_evt  = rx_vld_i && !fifo_full;
  assign drop_evt  = rx_vld_i && fifo_full;
  assign pop_evt   = wr_vld_o && wr_rdy_i;
  assign mode_idle = fifo_empty && !pack_busy && !rx_vld_i;

  rxpk_mode_ctl u_mode (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .narrow_req_i (narrow_i),
    .idle_i       (mode_idle),
    .mode_o       (mode_q)
  );

  rxpk_packer u_packer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (take_evt),
    .byte_i  (rx_byte_i),
    .eof_i   (rx_eof_i),
    .mode_i  (mode_q),
    .push_o  (push_evt),
    .entry_o (push_entry),
    .busy_o  (pack_busy)
  );

  rxpk_store #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
  ) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_i       (push_evt),
    .push_entry_i (push_entry),
    .pop_i        (pop_evt),
    .cap_i        (fifo_cap),
    .head_o       (head),
    .count_o      (fifo_count),
    .full_o       (fifo_full),
    .empty_o      (fifo_empty)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) ovf_q <= 1'b0;
    else         ovf_q <= drop_evt;
  end

  assign wr_vld_o  = !fifo_empty;
  assign wr_data_o = wr_vld_o ? head.data : '0;
  assign wr_be_o   = wr_vld_o ? head.be : '0;
  assign ovf_o     = ovf_q;

endmodule

// File: rtl/rxpk_checker.sv
module rxpk_checker
  import rxpk_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_vld_i,
  input logic              wr_vld_o,
  input logic              wr_rdy_i,
  input logic [WORD_W-1:0] wr_data_o,
  input logic [LANES-1:0]  wr_be_o,
  input logic              ovf_o,
  input rx_mode_e          mode_q,
  input logic [CNT_W-1:0]  fifo_count,
  input logic [CNT_W-1:0]  fifo_cap,
  input logic              fifo_full,
  input logic              pack_busy,
  input logic              push_evt,
  input logic              pop_evt
);

  assert_count_within_cap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_count <= fifo_cap);

  assert_ovf_after_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> $past(rx_vld_i && fifo_full));

  assert_narrow_single_lane_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_vld_o && mode_q == MODE_NARROW) |-> (wr_be_o == LANES'(1) && wr_data_o[WORD_W-1:BYTE_W] == '0));

  assert_lanes_from_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_vld_o |-> (wr_be_o != '0 && (wr_be_o & (wr_be_o + 1'b1)) == '0));

  assert_mode_switch_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != $past(mode_q)) |-> $past(fifo_count == '0 && !pack_busy));

  assert_hold_while_stalled_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_vld_o && !wr_rdy_i) |=> (wr_vld_o && $stable(wr_data_o) && $stable(wr_be_o)));

  assert_count_follows_events_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> fifo_count == $past(fifo_count + CNT_W'(push_evt) - CNT_W'(pop_evt)));

endmodule

bind rx_pack_fifo rxpk_checker #(.CNT_W(CNT_W)) u_rxpk_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rx_vld_i   (rx_vld_i),
  .wr_vld_o   (wr_vld_o),
  .wr_rdy_i   (wr_rdy_i),
  .wr_data_o  (wr_data_o),
  .wr_be_o    (wr_be_o),
  .ovf_o      (ovf_o),
  .mode_q     (mode_q),
  .fifo_count (fifo_count),
  .fifo_cap   (fifo_cap),
  .fifo_full  (fifo_full),
  .pack_busy  (pack_busy),
  .push_evt   (push_evt),
  .pop_evt    (pop_evt)
);

// File: tb/test_rx_pack_fifo.sv
module test_rx_pack_fifo;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        narrow;
  logic        rx_vld;
  logic [7:0]  rx_byte;
  logic        rx_eof;
  logic        wr_vld;
  logic        wr_rdy;
  logic [31:0] wr_data;
  logic [3:0]  wr_be;
  logic        ovf;

  int n_checks = 0;
  int n_err    = 0;

  always #10 clk = ~clk;

  rx_pack_fifo i_rx_pack_fifo (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .narrow_i  (narrow),
    .rx_vld_i  (rx_vld),
    .rx_byte_i (rx_byte),
    .rx_eof_i  (rx_eof),
    .wr_vld_o  (wr_vld),
    .wr_rdy_i  (wr_rdy),
    .wr_data_o (wr_data),
    .wr_be_o   (wr_be),
    .ovf_o     (ovf)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic expect_head(input string req, input logic [31:0] d, input logic [3:0] be);
    check(req, "valid", 32'(wr_vld), 32'd1);
    check(req, "data", wr_data, d);
    check(req, "be", 32'(wr_be), 32'(be));
  endtask

  task automatic send(input logic [7:0] b, input logic eof);
    rx_vld = 1'b1; rx_byte = b; rx_eof = eof;
    @(negedge clk);
    rx_vld = 1'b0; rx_eof = 1'b0;
  endtask

  task automatic pop_one();
    wr_rdy = 1'b1;
    @(negedge clk);
    wr_rdy = 1'b0;
  endtask

  task automatic send_pop(input logic [7:0] b);
    rx_vld = 1'b1; rx_byte = b; rx_eof = 1'b0; wr_rdy = 1'b1;
    @(negedge clk);
    rx_vld = 1'b0; wr_rdy = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1", "valid", 32'(wr_vld), 32'd0);
    check("R1", "ovf", 32'(ovf), 32'd0);
    check("R1", "data", wr_data, 32'd0);
    check("R1", "be", 32'(wr_be), 32'd0);
  endtask

  task automatic t_wide_pack();
    send(8'hA1, 1'b0); check("R3", "no write after 1", 32'(wr_vld), 32'd0);
    send(8'hB2, 1'b0); check("R3", "no write after 2", 32'(wr_vld), 32'd0);
    send(8'hC3, 1'b0); check("R3", "no write after 3", 32'(wr_vld), 32'd0);
    send(8'hD4, 1'b0);
    expect_head("R2", 32'hD4C3_B2A1, 4'hF);
    pop_one();
    check("R2", "empty after pop", 32'(wr_vld), 32'd0);
  endtask

  task automatic t_eof_flush();
    send(8'h11, 1'b0);
    send(8'h22, 1'b1);
    expect_head("R4", 32'h0000_2211, 4'b0011);
    pop_one();
    send(8'h77, 1'b1);
    expect_head("R4", 32'h0000_0077, 4'b0001);
    pop_one();
    send(8'h01, 1'b0); send(8'h02, 1'b0); send(8'h03, 1'b1);
    expect_head("R4", 32'h0003_0201, 4'b0111);
    pop_one();
    check("R4", "empty", 32'(wr_vld), 32'd0);
  endtask

  task automatic t_narrow();
    narrow = 1'b1; idle(2);
    send(8'h5A, 1'b0);
    expect_head("R5", 32'h0000_005A, 4'b0001);
    pop_one();
    check("R5", "empty", 32'(wr_vld), 32'd0);
  endtask

  task automatic t_narrow_capacity();
    for (int i = 0; i < 8; i++) send(8'h10 + 8'(i), 1'b0);
    check("R6", "no ovf at 8 chars", 32'(ovf), 32'd0);
    send(8'hEE, 1'b0);
    check("R6", "ovf pulse", 32'(ovf), 32'd1);
    idle(1);
    check("R6", "ovf one cycle", 32'(ovf), 32'd0);
    for (int i = 0; i < 8; i++) begin
      expect_head("R9", {24'd0, 8'h10 + 8'(i)}, 4'b0001);
      pop_one();
    end
    check("R6", "dropped char absent", 32'(wr_vld), 32'd0);
  endtask

  task automatic t_same_cycle();
    send(8'h61, 1'b0);
    send_pop(8'h62);
    expect_head("R10", 32'h0000_0062, 4'b0001);
    pop_one();
    check("R10", "empty", 32'(wr_vld), 32'd0);
    for (int i = 0; i < 8; i++) send(8'h20 + 8'(i), 1'b0);
    send_pop(8'hEE);
    check("R7", "ovf pulse", 32'(ovf), 32'd1);
    for (int i = 1; i < 8; i++) begin
      expect_head("R7", {24'd0, 8'h20 + 8'(i)}, 4'b0001);
      pop_one();
    end
    check("R7", "dropped char absent", 32'(wr_vld), 32'd0);
  endtask

  task automatic t_wide_capacity();
    narrow = 1'b0; idle(2);
    for (int i = 0; i < 32; i++) send(8'(i), 1'b0);
    check("R6", "no ovf at 32 bytes", 32'(ovf), 32'd0);
    send(8'hEE, 1'b1);
    check("R6", "wide ovf pulse", 32'(ovf), 32'd1);
    for (int k = 0; k < 8; k++) begin
      expect_head("R6", {8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)}, 4'hF);
      pop_one();
    end
    check("R6", "wide drained", 32'(wr_vld), 32'd0);
  endtask

  task automatic t_mode_defer();
    send(8'h81, 1'b0); send(8'h82, 1'b0);
    narrow = 1'b1; idle(2);
    send(8'h83, 1'b0); send(8'h84, 1'b0);
    expect_head("R8", 32'h8483_8281, 4'hF);
    pop_one();
    idle(2);
    send(8'h91, 1'b0);
    expect_head("R8", 32'h0000_0091, 4'b0001);
    narrow = 1'b0; idle(2);
    send(8'h92, 1'b0);
    expect_head("R8", 32'h0000_0091, 4'b0001);
    pop_one();
    expect_head("R8", 32'h0000_0092, 4'b0001);
    pop_one();
    idle(2);
    send(8'h41, 1'b0); send(8'h42, 1'b1);
    expect_head("R8", 32'h0000_4241, 4'b0011);
    pop_one();
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; narrow = 1'b0; rx_vld = 1'b0; rx_byte = '0; rx_eof = 1'b0; wr_rdy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_wide_pack();
    t_eof_flush();
    t_narrow();
    t_narrow_capacity();
    t_same_cycle();
    t_wide_capacity();
    t_mode_defer();
    summary();
    $finish;
  end

endmodule